// File: doc/BRIEF.md
# Pseudo-Exhaustive Ripple-Carry Adder Self-Test Controller

This block is a built-in self-test controller for an N-bit ripple-carry adder. After a start request it applies a fixed run of eight operand and carry-in patterns to the adder, one pattern per clock. It checks each response (sum and carry-out) against the arithmetic sum of the same operands, computed inside the tester. When the run ends it pulses `done` and reports a pass flag. On a failure it also reports the number of the first pattern that mismatched.

The patterns are built so that, across the eight of them, every full-adder cell of the chain receives all eight combinations of (carry-in, a, b). Bit 0 receives the pattern number itself. Each higher bit picks its operand bits from the carry that the fault-free chain delivers to it from the bit below. The test therefore has the same length for any width. The method relies on each cell's carry coming from its lower neighbour. A parameterised ripple-carry adder built from full-adder cells is included as the intended device under test.

Top module: `rca_pe_tester`

## Requirements
- R1: While reset is held and directly after it, `done`, `pass`, `fail_index`, `tst_a`, `tst_b` and `tst_cin` are all 0.
- R2: A start sampled high in idle is followed by `done` high for exactly one cycle. That cycle comes after the 8th rising edge following the edge that sampled start.
- R3: Pattern k (k = 0..7) is on the operand outputs during the cycle after the k-th rising edge following the start edge. It has `tst_cin` = k[2]. Bit 0 has (a,b) = (k[1],k[0]). A higher bit i takes (k[1],k[0]) when the fault-free carry into bit i equals k[2], and (~k[1],~k[0]) otherwise. Outside a run the operand outputs are 0.
- R4: Over the eight patterns, every cell of a fault-free chain receives each of the eight (carry-in,a,b) triples at least once.
- R5: If every response equals {carry-out, sum} = a + b + carry-in (N+1 bits), `pass` is 1 when `done` is high.
- R6: If any response mismatches, `pass` is 0 at `done`, and `fail_index` holds the lowest mismatching pattern number. `fail_index` is 0 whenever `pass` is 1.
- R7: A start raised while a run is in progress is ignored: the run neither restarts nor shifts `done`.
- R8: `pass` and `fail_index` hold their values from `done` until the next accepted start. That start clears both to 0.
- R9: Any single stuck-at-0 or stuck-at-1 on any operand bit, any carry (including carry-in and carry-out) or any sum bit of the ripple chain gives `pass` = 0.
- R10: The included adder gives {`add_cout`,`add_sum`} = `add_a` + `add_b` + `add_cin` for all operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run when idle |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Run verdict, valid from `done` until the next start |
| fail_index | output | 3 | First mismatching pattern number |
| tst_a | output | N | Operand A to the adder under test |
| tst_b | output | N | Operand B to the adder under test |
| tst_cin | output | 1 | Carry-in to the adder under test |
| rsp_sum | input | N | Sum returned by the adder under test |
| rsp_cout | input | 1 | Carry-out returned by the adder under test |

## Verification
The hardest situation to reach from the ports is a fault deep inside the carry chain, such as an internal carry stuck at one value. A fault there only shows in the few patterns where that carry should take the other value. The bench rebuilds the adder from individual cells, with a stuck-at injector on every operand, carry and sum net. It steps through every single fault, and then random ones from a fixed seed, comparing the verdict and first-fail number with its own faulty-chain model. Deliberate response corruption on random subsets of patterns, together with start pulses raised mid-run, exercises the lowest-index capture and the ignored-start rule.

// File: rtl/rca_bist_pkg.sv
package rca_bist_pkg;

    localparam int PAT_COUNT = 8;
    localparam int PAT_W     = $clog2(PAT_COUNT);

    typedef logic [PAT_W-1:0] pat_idx_t;

    // Patterns whose bit-0 cell generates/kills, so carries alternate along the chain
    localparam pat_idx_t ALT_LO = pat_idx_t'(3);
    localparam pat_idx_t ALT_HI = pat_idx_t'(4);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } bist_state_e;

    typedef struct packed {
        bist_state_e state;
        pat_idx_t    idx;
        logic        err;
        pat_idx_t    fidx;
        logic        pass;
    } bist_ctl_t;

endpackage

// File: rtl/rca_fa_cell.sv
module rca_fa_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
    end
endmodule

// File: rtl/rca_adder.sv
module rca_adder #(
    parameter int N = 8
) (
    input  logic [N-1:0] add_a,
    input  logic [N-1:0] add_b,
    input  logic         add_cin,
    output logic [N-1:0] add_sum,
    output logic         add_cout
);
    logic [N:0] carry;

    assign carry[0] = add_cin;

    for (genvar i = 0; i < N; i++) begin : g_cell
        rca_fa_cell u_cell (
            .x  (add_a[i]),
            .y  (add_b[i]),
            .ci (carry[i]),
            .s  (add_sum[i]),
            .co (carry[i+1])
        );
    end

    assign add_cout = carry[N];
endmodule

// File: rtl/rca_bist_patgen.sv
module rca_bist_patgen
    import rca_bist_pkg::*;
#(
    parameter int N = 8
) (
    input  pat_idx_t     idx,
    output logic [N-1:0] op_a,
    output logic [N-1:0] op_b,
    output logic         op_cin
);
    // In the alternating patterns the fault-free carry into odd bits is the
    // complement of the chain carry-in, so those bits take complemented operands.
    logic alt;

    assign alt    = (idx == ALT_LO) || (idx == ALT_HI);
    assign op_cin = idx[2];

    for (genvar i = 0; i < N; i++) begin : g_bit
        if ((i % 2) == 1) begin : g_odd
            assign op_a[i] = idx[1] ^ alt;
            assign op_b[i] = idx[0] ^ alt;
        end else begin : g_even
            assign op_a[i] = idx[1];
            assign op_b[i] = idx[0];
        end
    end
endmodule

// File: rtl/rca_bist_resp.sv
module rca_bist_resp #(
    parameter int N = 8
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         op_cin,
    input  logic [N-1:0] rsp_sum,
    input  logic         rsp_cout,
    output logic         mismatch
);
    localparam int RW = N + 1;

    logic [RW-1:0] golden;

    always_comb begin
        golden   = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, op_cin};
        mismatch = (golden != {rsp_cout, rsp_sum});
    end
endmodule

// File: rtl/rca_pe_tester.sv
module rca_pe_tester
    import rca_bist_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic         done,
    output logic         pass,
    output logic [2:0]   fail_index,
    output logic [N-1:0] tst_a,
    output logic [N-1:0] tst_b,
    output logic         tst_cin,
    input  logic [N-1:0] rsp_sum,
    input  logic         rsp_cout
);
    localparam pat_idx_t LAST_IDX = pat_idx_t'(PAT_COUNT - 1);

    bist_ctl_t st_d, st_q;

    logic         run_w;
    logic [N-1:0] pg_a, pg_b;
    logic         pg_cin;
    logic         mism;

    assign run_w = (st_q.state == ST_RUN);

    rca_bist_patgen #(.N(N)) u_patgen (
        .idx    (st_q.idx),
        .op_a   (pg_a),
        .op_b   (pg_b),
        .op_cin (pg_cin)
    );

    assign tst_a   = run_w ? pg_a   : '0;
    assign tst_b   = run_w ? pg_b   : '0;
    assign tst_cin = run_w ? pg_cin : 1'b0;

    rca_bist_resp #(.N(N)) u_resp (
        .op_a     (tst_a),
        .op_b     (tst_b),
        .op_cin   (tst_cin),
        .rsp_sum  (rsp_sum),
        .rsp_cout (rsp_cout),
        .mismatch (mism)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.state = ST_RUN;
                    st_d.idx   = '0;
                    st_d.err   = 1'b0;
                    st_d.fidx  = '0;
                    st_d.pass  = 1'b0;
                end
            end
            ST_RUN: begin
                if (mism && !st_q.err) begin
                    st_d.err  = 1'b1;
                    st_d.fidx = st_q.idx;
                end
                if (st_q.idx == LAST_IDX) begin
                    st_d.state = ST_FIN;
                    st_d.pass  = !(st_q.err || mism);
                end else begin
                    st_d.idx = st_q.idx + pat_idx_t'(1);
                end
            end
            ST_FIN: begin
                st_d.state = ST_IDLE;
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, idx: '0, err: 1'b0, fidx: '0, pass: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done       = (st_q.state == ST_FIN);
    assign pass       = st_q.pass;
    assign fail_index = st_q.fidx;

endmodule

// File: rtl/rca_bist_chk.sv
module rca_bist_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       pass,
    input logic [2:0] fail_index,
    input logic [2:0] pat_lo,
    input logic       running,
    input logic [2:0] idx
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    pat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> (pat_lo == $past(pat_lo) + 3'd1));

    // R7
    run_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && idx != 3'd7) |=> (running && idx == $past(idx) + 3'd1));

    // R5
    pass_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass) |-> done);

    // R6
    pass_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (fail_index == 3'd0));

    // R8
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !done && $past(!running && !done))
            |-> ($stable(pass) && $stable(fail_index)));
endmodule

bind rca_pe_tester rca_bist_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .pass       (pass),
    .fail_index (fail_index),
    .pat_lo     ({tst_cin, tst_a[0], tst_b[0]}),
    .running    (run_w),
    .idx        (st_q.idx)
);

// File: tb/rca_pe_tester_tb.sv
module rca_pe_tester_tb;
    localparam int N     = 8;
    localparam int NSITE = 4 * N + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         done, pass;
    logic [2:0]   fail_index;
    logic [N-1:0] tst_a, tst_b;
    logic         tst_cin;
    logic [N-1:0] rsp_sum;
    logic         rsp_cout;

    int n_chk = 0;
    int n_bad = 0;

    // fault and corruption controls
    logic       f_en = 1'b0;
    int         f_site = 0;
    logic       f_val = 1'b0;
    logic       sel_chain = 1'b0;
    logic [7:0] flip_mask = 8'h00;

    always #5 clk = ~clk;

    rca_pe_tester #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
        .fail_index(fail_index), .tst_a(tst_a), .tst_b(tst_b), .tst_cin(tst_cin),
        .rsp_sum(rsp_sum), .rsp_cout(rsp_cout)
    );

    // fault-free included adder
    logic [N-1:0] ad_sum;
    logic         ad_cout;
    rca_adder #(.N(N)) u_add (
        .add_a(tst_a), .add_b(tst_b), .add_cin(tst_cin),
        .add_sum(ad_sum), .add_cout(ad_cout)
    );

    // cell chain with a stuck-at injector on every net
    logic [N-1:0] ia, ib, raw_s, is_w;
    logic [N:0]   raw_c, ic;
    assign raw_c[0] = tst_cin;
    for (genvar i = 0; i < N; i++) begin : g_fc
        assign ia[i] = (f_en && f_site == i) ? f_val : tst_a[i];
        assign ib[i] = (f_en && f_site == N + i) ? f_val : tst_b[i];
        rca_fa_cell u_fc (.x(ia[i]), .y(ib[i]), .ci(ic[i]), .s(raw_s[i]), .co(raw_c[i+1]));
        assign is_w[i] = (f_en && f_site == 3 * N + 1 + i) ? f_val : raw_s[i];
    end
    for (genvar j = 0; j <= N; j++) begin : g_fcar
        assign ic[j] = (f_en && f_site == 2 * N + j) ? f_val : raw_c[j];
    end

    always_comb begin
        logic [N:0] r;
        r = sel_chain ? {ic[N], is_w} : {ad_cout, ad_sum};
        if (flip_mask[{tst_cin, tst_a[0], tst_b[0]}]) r[0] = ~r[0];
        {rsp_cout, rsp_sum} = r;
    end

    // separate adder for direct arithmetic checks
    logic [N-1:0] ra, rb, rs;
    logic         rc, rco;
    rca_adder #(.N(N)) u_ref_add (
        .add_a(ra), .add_b(rb), .add_cin(rc), .add_sum(rs), .add_cout(rco)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pattern k built by walking the fault-free carry along the chain
    function automatic void pat_ops(input int k, output logic [N-1:0] a,
                                    output logic [N-1:0] b, output logic cin);
        logic c, kc, ka, kb;
        kc = k[2]; ka = k[1]; kb = k[0];
        cin = kc;
        c = kc;
        for (int i = 0; i < N; i++) begin
            if (c == kc) begin a[i] = ka; b[i] = kb; end
            else begin a[i] = ~ka; b[i] = ~kb; end
            c = (c & a[i]) | (c & b[i]) | (a[i] & b[i]);
        end
    endfunction

    function automatic logic injb(input logic v, input int here, input int site,
                                  input logic val);
        return (here == site) ? val : v;
    endfunction

    // first pattern on which a single stuck-at fault shows, -1 if none
    function automatic int model_first(input int site, input logic val);
        logic [N-1:0] a, b, s;
        logic cin, c, x, y;
        longint good, got;
        for (int k = 0; k < 8; k++) begin
            pat_ops(k, a, b, cin);
            good = longint'(a) + longint'(b) + longint'(cin);
            c = injb(cin, 2 * N, site, val);
            for (int i = 0; i < N; i++) begin
                x = injb(a[i], i, site, val);
                y = injb(b[i], N + i, site, val);
                s[i] = injb(x ^ y ^ c, 3 * N + 1 + i, site, val);
                c = injb((x & y) | (x & c) | (y & c), 2 * N + i + 1, site, val);
            end
            got = {c, s};
            if (got != good) return k;
        end
        return -1;
    endfunction

    logic [7:0] seen [N];

    task automatic run_test(input bit glitch, input int gk, input int idle,
                            input bit chk_ops, output logic got_pass,
                            output logic [2:0] got_fi);
        logic [N-1:0] ea, eb;
        logic ec, c;
        repeat (idle) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (chk_ops) begin
                pat_ops(k, ea, eb, ec);
                chk($sformatf("R3 a pat %0d", k), longint'(tst_a), longint'(ea));
                chk($sformatf("R3 b pat %0d", k), longint'(tst_b), longint'(eb));
                chk($sformatf("R3 cin pat %0d", k), longint'(tst_cin), longint'(ec));
                chk($sformatf("R2 no early done %0d", k), longint'(done), 0);
                if (k == 0) chk("R8 start clears pass", longint'(pass), 0);
                c = tst_cin;
                for (int i = 0; i < N; i++) begin
                    seen[i][{c, tst_a[i], tst_b[i]}] = 1'b1;
                    c = (c & tst_a[i]) | (c & tst_b[i]) | (tst_a[i] & tst_b[i]);
                end
            end
            start = glitch && (k == gk);
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2/R7 done pulse", longint'(done), 1);
        got_pass = pass;
        got_fi = fail_index;
        @(negedge clk);
        chk("R2 done one cycle", longint'(done), 0);
        chk("R8 pass held", longint'(pass), longint'(got_pass));
        chk("R8 index held", longint'(fail_index), longint'(got_fi));
        if (chk_ops) chk("R3 idle operands", longint'({tst_cin, tst_a, tst_b}), 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic p;
        logic [2:0] fi;
        int first, lo, site;
        logic v;
        longint exp_sum;
        void'($urandom(32'd20251));
        for (int i = 0; i < N; i++) seen[i] = 8'h00;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 done", longint'(done), 0);
        chk("R1 pass", longint'(pass), 0);
        chk("R1 fail_index", longint'(fail_index), 0);
        chk("R1 operands", longint'({tst_cin, tst_a, tst_b}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", longint'({done, pass, fail_index}), 0);

        // R10: adder arithmetic, corners then random
        for (int t = 0; t < 44; t++) begin
            case (t)
                0: begin ra = '0; rb = '0; rc = 1'b0; end
                1: begin ra = '1; rb = '1; rc = 1'b1; end
                2: begin ra = '1; rb = '0; rc = 1'b1; end
                3: begin ra = 8'h55; rb = 8'hAA; rc = 1'b0; end
                default: begin ra = N'($urandom); rb = N'($urandom); rc = 1'($urandom); end
            endcase
            #1;
            exp_sum = longint'(ra) + longint'(rb) + longint'(rc);
            chk("R10 adder sum", longint'({rco, rs}), exp_sum);
        end
        @(negedge clk);

        // R5/R4: fault-free run with operand checks
        run_test(1'b0, 0, 0, 1'b1, p, fi);
        chk("R5 fault-free pass", longint'(p), 1);
        chk("R6 fault-free index", longint'(fi), 0);
        for (int i = 0; i < N; i++)
            chk($sformatf("R4 cell %0d triples", i), longint'(seen[i]), 8'hFF);

        // R6: single corrupted pattern, each k
        for (int k = 0; k < 8; k++) begin
            flip_mask = 8'(1 << k);
            run_test(1'b0, 0, 1, 1'b0, p, fi);
            chk($sformatf("R6 flip %0d pass", k), longint'(p), 0);
            chk($sformatf("R6 flip %0d index", k), longint'(fi), longint'(k));
        end

        // R6/R7: random corruption subsets with mid-run start pulses
        for (int t = 0; t < 12; t++) begin
            flip_mask = 8'($urandom_range(1, 255));
            lo = 0;
            while (!flip_mask[lo]) lo++;
            run_test(1'($urandom), $urandom_range(0, 7), $urandom_range(0, 3),
                     1'b1, p, fi);
            chk("R6 subset pass", longint'(p), 0);
            chk("R6 lowest index", longint'(fi), longint'(lo));
        end
        flip_mask = 8'h00;

        // R5 again after failures, R7 with start held during run
        run_test(1'b1, 7, 2, 1'b1, p, fi);
        chk("R5/R7 pass after glitch", longint'(p), 1);

        // R9: every single stuck-at in the cell chain
        sel_chain = 1'b1;
        f_en = 1'b0;
        run_test(1'b0, 0, 0, 1'b0, p, fi);
        chk("R5 chain fault-free pass", longint'(p), 1);
        f_en = 1'b1;
        for (int s = 0; s < NSITE; s++) begin
            for (int vv = 0; vv < 2; vv++) begin
                f_site = s;
                f_val = vv[0];
                first = model_first(s, vv[0]);
                run_test(1'b0, 0, 0, 1'b0, p, fi);
                chk($sformatf("R9 site %0d sa%0d pass", s, vv), longint'(p), 0);
                chk($sformatf("R6 site %0d sa%0d index", s, vv), longint'(fi),
                    longint'(first < 0 ? 0 : first));
            end
        end

        // R9: random single faults with random gaps and start glitches
        for (int t = 0; t < 20; t++) begin
            site = $urandom_range(0, NSITE - 1);
            v = 1'($urandom);
            f_site = site;
            f_val = v;
            first = model_first(site, v);
            run_test(1'($urandom), $urandom_range(0, 7), $urandom_range(0, 4),
                     1'b0, p, fi);
            chk("R9 random fault pass", longint'(p), 0);
            chk("R6 random fault index", longint'(fi),
                longint'(first < 0 ? 0 : first));
        end
        f_en = 1'b0;

        summary();
        $finish;
    end
endmodule